// File: doc/BRIEF.md
# MSI Record Ring Writer

This block takes message-signalled interrupt writes that have already been decoded to it, each carrying one 32-bit data word, and stores each one as a 16-byte record in a circular buffer in system memory. The buffer is sized by software and placed by a 64-bit base address. Its position is tracked by a pair of offsets. The block owns the producer offset and advances it after each record it writes. Software owns the consumer offset and advances it as it drains records. While the two offsets differ and interrupts are enabled, a level interrupt is raised toward the host.

Software programs the base address, the ring size and the control bits through a small word-addressed register port. Messages arrive on a valid/ready port. Each record goes out as four 32-bit word writes on a request/acknowledge memory port. When the ring fills, the control bits select one of three behaviours: hold the inbound port, discard the message and note it in a sticky flag, or keep writing regardless.

Top module: `msi_ring_writer`

## Requirements
- R1: After reset every register reads as zero, msg_ready, mem_req and irq are low, and the producer offset is zero.
- R2: Register word addresses are 0 control, 3 base address bits 63:32, 4 base address bits 31:0, 5 consumer offset, 6 producer offset (read-only; writes to it are ignored); other addresses read as zero. Control bits are 0 enable, 1 full detection, 2 overflow flag (read), 3 interrupt enable, 4 stop-on-full, 9:8 ring size select, and read back as written.
- R3: A record occupies four consecutive 32-bit words at base plus producer offset, written in ascending address order; the first word is the message data (byte 0 at the lowest address, so data bits 15:0 are the interrupt number), and the other three words are zero.
- R4: Each word request, once raised, holds its address and data stable until acknowledged, and the producer offset changes only after the fourth word of a record is acknowledged.
- R5: The ring holds 2^(15+size select) bytes; after the record at offset size minus 16 the producer offset returns to zero, and its readback never exceeds size minus 16.
- R6: The ring is full when producer plus 16, modulo the size, equals the consumer offset; with full detection and stop-on-full both set, msg_ready stays low while the ring is full and no write is issued, and the held message is accepted once the consumer offset moves.
- R7: With full detection set and stop-on-full clear, a message arriving at a full ring is accepted but not written, the producer offset does not move, and the overflow flag (control bit 2) sets; it stays set until a control write with bit 2 at one clears it.
- R8: With full detection clear, a message is always written, even when that makes the producer offset equal the consumer offset.
- R9: With enable clear, msg_ready is low and no memory write starts.
- R10: irq is high exactly when interrupt enable is set and the producer and consumer offsets differ.
- R11: A consumer offset write keeps only bits 4 up to the ring size; its low four bits read as zero, and changing the size re-masks the stored consumer offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| msg_valid | input | 1 | Inbound message present |
| msg_data | input | 32 | Inbound message data word |
| msg_ready | output | 1 | Block accepts the message this cycle |
| mem_req | output | 1 | Memory word write request |
| mem_addr | output | ADDR_W (64) | Byte address of the word |
| mem_wdata | output | 32 | Word data |
| mem_ack | input | 1 | Memory accepted the word |
| irq | output | 1 | Level interrupt to host |

## Verification
The bench runs the producer offset across the whole 32 KB ring. A design with an off-by-one wrap would write past the last record or skip offset zero. A stalled acknowledge checks that the producer offset does not move early; if it did, software could read a record that was only partly written. The three full-ring policies are each driven to their limit. A wrong design would either corrupt unread records by writing into a full ring, lose the held message when the consumer moves, or set the overflow flag without dropping the message. The bench also checks that the flag does not clear on a write of zero to bit 2. Consumer-offset masking across a size change is checked, since a stale high bit would make the full test never match.

// File: rtl/msi_ring_pkg.sv
package msi_ring_pkg;

    localparam int DATA_W      = 32;
    localparam int REG_AW      = 3;
    localparam int SEL_W       = 2;
    localparam int SIZE_EXP_MIN = 15;
    localparam int OFF_W       = SIZE_EXP_MIN + (1 << SEL_W) - 1;
    localparam int REC_BYTES   = 16;
    localparam int REC_SHIFT   = $clog2(REC_BYTES);
    localparam int WORD_BYTES  = DATA_W / 8;
    localparam int REC_WORDS   = REC_BYTES / WORD_BYTES;
    localparam int WIDX_W      = $clog2(REC_WORDS);

    typedef enum logic [REG_AW-1:0] {
        RA_CTRL    = 3'h0,
        RA_BASE_HI = 3'h3,
        RA_BASE_LO = 3'h4,
        RA_CONS    = 3'h5,
        RA_PROD    = 3'h6
    } reg_addr_e;

    localparam int CB_ENABLE = 0;
    localparam int CB_FULLDET = 1;
    localparam int CB_OVF_CLR = 2;
    localparam int CB_IRQ_EN = 3;
    localparam int CB_STOP   = 4;
    localparam int CB_SEL_LO = 8;

    typedef struct packed {
        logic             enable;
        logic             full_det;
        logic             irq_en;
        logic             stop_full;
        logic [SEL_W-1:0] size_sel;
    } ctrl_t;

    typedef enum logic {
        WR_IDLE,
        WR_BUSY
    } wr_state_e;

    // Offset mask: keeps record-aligned bits below the selected ring size.
    function automatic logic [OFF_W-1:0] ring_mask(input logic [SEL_W-1:0] sel);
        logic [OFF_W-1:0] m;
        m = '0;
        for (int i = REC_SHIFT; i < OFF_W; i++) begin
            if (i < SIZE_EXP_MIN + int'(sel)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/msi_ring_regs.sv
module msi_ring_regs
    import msi_ring_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [OFF_W-1:0]      prod_off,
    input  logic                  ovf_set,
    output ctrl_t                 ctrl,
    output logic [ADDR_W-1:0]     base,
    output logic [OFF_W-1:0]      cons_off
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] base_hi;
        logic [DATA_W-1:0] base_lo;
        logic [OFF_W-1:0]  cons;
        logic              ovf;
    } regs_t;

    regs_t st_d, st_q;
    logic  ctrl_wr;
    logic  ovf_clr;

    assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
    assign ovf_clr = ctrl_wr && reg_wdata[CB_OVF_CLR];

    always_comb begin
        st_d = st_q;
        if (ovf_set) st_d.ovf = 1'b1;
        if (reg_wr) begin
            unique case (reg_addr)
                RA_CTRL: begin
                    st_d.ctrl.enable    = reg_wdata[CB_ENABLE];
                    st_d.ctrl.full_det  = reg_wdata[CB_FULLDET];
                    st_d.ctrl.irq_en    = reg_wdata[CB_IRQ_EN];
                    st_d.ctrl.stop_full = reg_wdata[CB_STOP];
                    st_d.ctrl.size_sel  = reg_wdata[CB_SEL_LO +: SEL_W];
                    st_d.cons = st_q.cons & ring_mask(reg_wdata[CB_SEL_LO +: SEL_W]);
                    if (reg_wdata[CB_OVF_CLR]) st_d.ovf = 1'b0;
                end
                RA_BASE_HI: st_d.base_hi = reg_wdata;
                RA_BASE_LO: st_d.base_lo = reg_wdata;
                RA_CONS:    st_d.cons = reg_wdata[OFF_W-1:0] & ring_mask(st_q.ctrl.size_sel);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            RA_CTRL: begin
                reg_rdata[CB_ENABLE]             = st_q.ctrl.enable;
                reg_rdata[CB_FULLDET]            = st_q.ctrl.full_det;
                reg_rdata[CB_OVF_CLR]            = st_q.ovf;
                reg_rdata[CB_IRQ_EN]             = st_q.ctrl.irq_en;
                reg_rdata[CB_STOP]               = st_q.ctrl.stop_full;
                reg_rdata[CB_SEL_LO +: SEL_W]    = st_q.ctrl.size_sel;
            end
            RA_BASE_HI: reg_rdata = st_q.base_hi;
            RA_BASE_LO: reg_rdata = st_q.base_lo;
            RA_CONS:    reg_rdata[OFF_W-1:0] = st_q.cons;
            RA_PROD:    reg_rdata[OFF_W-1:0] = prod_off;
            default:    reg_rdata = '0;
        endcase
    end

    assign ctrl     = st_q.ctrl;
    assign base     = ADDR_W'({st_q.base_hi, st_q.base_lo});
    assign cons_off = st_q.cons;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !ovf_clr) |=> st_q.ovf) else $error("overflow flag lost"); // R7

endmodule

// File: rtl/msi_ring_fsm.sv
module msi_ring_fsm
    import msi_ring_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  ctrl_t              ctrl,
    input  logic [ADDR_W-1:0]  base,
    input  logic [OFF_W-1:0]   cons_off,
    input  logic               msg_valid,
    input  logic [DATA_W-1:0]  msg_data,
    output logic               msg_ready,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_wdata,
    input  logic               mem_ack,
    output logic [OFF_W-1:0]   prod_off,
    output logic               ovf_set
);

    localparam logic [WIDX_W-1:0] LAST_WORD = WIDX_W'(REC_WORDS - 1);
    localparam logic [OFF_W-1:0]  REC_STEP  = OFF_W'(REC_BYTES);

    typedef struct packed {
        wr_state_e         state;
        logic [WIDX_W-1:0] widx;
        logic [OFF_W-1:0]  prod;
        logic [DATA_W-1:0] data;
    } fsm_t;

    fsm_t st_d, st_q;

    logic [OFF_W-1:0] mask;
    logic [OFF_W-1:0] prod_m;
    logic [OFF_W-1:0] prod_next;
    logic             ring_full;
    logic             hold_off;
    logic             discard;
    logic             accept;
    logic             last_ack;

    always_comb begin
        mask      = ring_mask(ctrl.size_sel);
        prod_m    = st_q.prod & mask;
        prod_next = (prod_m + REC_STEP) & mask;
        ring_full = (prod_next == cons_off);
        hold_off  = ring_full && ctrl.full_det && ctrl.stop_full;
        discard   = ring_full && ctrl.full_det && !ctrl.stop_full;
        msg_ready = ctrl.enable && (st_q.state == WR_IDLE) && !hold_off;
        accept    = msg_valid && msg_ready;
        last_ack  = (st_q.state == WR_BUSY) && mem_ack && (st_q.widx == LAST_WORD);
    end

    always_comb begin
        st_d    = st_q;
        ovf_set = 1'b0;
        unique case (st_q.state)
            WR_IDLE: begin
                if (accept) begin
                    if (discard) begin
                        ovf_set = 1'b1;
                    end else begin
                        st_d.state = WR_BUSY;
                        st_d.widx  = '0;
                        st_d.data  = msg_data;
                    end
                end
            end
            WR_BUSY: begin
                if (mem_ack) begin
                    if (st_q.widx == LAST_WORD) begin
                        st_d.prod  = prod_next;
                        st_d.state = WR_IDLE;
                    end else begin
                        st_d.widx = st_q.widx + 1'b1;
                    end
                end
            end
            default: st_d.state = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mem_req   = (st_q.state == WR_BUSY);
    assign mem_addr  = base + ADDR_W'(prod_m) + ADDR_W'({st_q.widx, 2'b00});
    assign mem_wdata = (st_q.widx == '0) ? st_q.data : '0;
    assign prod_off  = prod_m;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)))
        else $error("request dropped or changed before ack"); // R4

    AST_PROD_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !last_ack |=> $stable(st_q.prod)) else $error("producer moved early"); // R4

    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_set |=> !mem_req) else $error("dropped message written"); // R7

endmodule

// File: rtl/msi_ring_writer.sv
module msi_ring_writer
    import msi_ring_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              msg_valid,
    input  logic [31:0]       msg_data,
    output logic              msg_ready,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic              mem_ack,
    output logic              irq
);

    ctrl_t             ctrl;
    logic [ADDR_W-1:0] base;
    logic [OFF_W-1:0]  cons_off;
    logic [OFF_W-1:0]  prod_off;
    logic              ovf_set;

    msi_ring_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .prod_off  (prod_off),
        .ovf_set   (ovf_set),
        .ctrl      (ctrl),
        .base      (base),
        .cons_off  (cons_off)
    );

    msi_ring_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl      (ctrl),
        .base      (base),
        .cons_off  (cons_off),
        .msg_valid (msg_valid),
        .msg_data  (msg_data),
        .msg_ready (msg_ready),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_ack   (mem_ack),
        .prod_off  (prod_off),
        .ovf_set   (ovf_set)
    );

    assign irq = ctrl.irq_en && (prod_off != cons_off);

    AST_NO_WRITE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.enable && !mem_req) |=> !mem_req) else $error("write while disabled"); // R9

    AST_IRQ_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !mem_req && $stable(cons_off)) |=> (irq || !ctrl.irq_en || $changed(cons_off)))
        else $error("irq fell with pending records"); // R10

endmodule

// File: tb/tb_msi_ring_writer.sv
module tb_msi_ring_writer;

    localparam int ADDR_W = 64;
    localparam logic [63:0] BASE = 64'h0000_0001_8000_0000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic [2:0]        reg_addr = '0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic              msg_valid = 1'b0;
    logic [31:0]       msg_data = '0;
    logic              msg_ready;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_wdata;
    logic              mem_ack;
    logic              irq;

    logic              ack_hold = 1'b0;
    logic [31:0]       words [0:8191];
    int                wcnt;
    int                checks = 0;
    int                errors = 0;

    always #10 clk = ~clk;

    msi_ring_writer #(.ADDR_W(ADDR_W)) dut (
        .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
        .msg_valid, .msg_data, .msg_ready,
        .mem_req, .mem_addr, .mem_wdata, .mem_ack, .irq
    );

    // Behavioural memory: acknowledges each word one cycle after it is seen.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else begin
            mem_ack <= mem_req && !mem_ack && !ack_hold;
            if (mem_req && mem_ack) begin
                words[((mem_addr - BASE) >> 2) & 64'h1FFF] <= mem_wdata;
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #2 d = reg_rdata;
    endtask

    task automatic send_msg(input logic [31:0] d);
        @(negedge clk);
        msg_valid = 1'b1; msg_data = d;
        while (!msg_ready) @(negedge clk);
        @(posedge clk); #1;
        msg_valid = 1'b0;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int a = 0; a < 8; a++) begin
            reg_read(3'(a), v);
            chk("R1 register zero", v, 0);
        end
        chk("R1 ready low", msg_ready, 0);
        chk("R1 req low", mem_req, 0);
        chk("R1 irq low", irq, 0);
    endtask

    task automatic t_regmap();
        logic [31:0] v;
        reg_write(3'h3, BASE[63:32]);
        reg_write(3'h4, BASE[31:0]);
        reg_read(3'h3, v); chk("R2 base hi", v, BASE[63:32]);
        reg_read(3'h4, v); chk("R2 base lo", v, BASE[31:0]);
        reg_write(3'h0, 32'h0000_031B);
        reg_read(3'h0, v); chk("R2 ctrl readback", v, 32'h31B);
        reg_write(3'h6, 32'h40);
        reg_read(3'h6, v); chk("R2 producer read-only", v, 0);
        reg_read(3'h7, v); chk("R2 unmapped zero", v, 0);
    endtask

    task automatic t_cons_mask();
        logic [31:0] v;
        reg_write(3'h5, 32'h0003_FFFF);
        reg_read(3'h5, v); chk("R11 cons 256KB mask", v, 32'h3FFF0);
        reg_write(3'h0, 32'h0000_0009);
        reg_read(3'h5, v); chk("R11 cons remask 32KB", v, 32'h7FF0);
        reg_write(3'h5, 32'h0001_2345);
        reg_read(3'h5, v); chk("R11 cons low bits", v, 32'h2340);
        reg_write(3'h5, 32'h0);
    endtask

    task automatic t_record();
        logic [31:0] v;
        send_msg(32'hA5A5_1234);
        settle();
        chk("R3 word0 data", words[0], 32'hA5A5_1234);
        chk("R3 word1 zero", words[1], 0);
        chk("R3 word2 zero", words[2], 0);
        chk("R3 word3 zero", words[3], 0);
        chk("R3 four writes", 64'(wcnt), 4);
        reg_read(3'h6, v); chk("R4 producer +16", v, 32'h10);
        chk("R10 irq pending", irq, 1);
        reg_write(3'h5, 32'h10);
        #2 chk("R10 irq drained", irq, 0);
        send_msg(32'hFFFF_0001);
        settle();
        chk("R3 second record", words[4], 32'hFFFF_0001);
        reg_read(3'h6, v); chk("R4 producer 0x20", v, 32'h20);
    endtask

    task automatic t_ack_hold();
        logic [31:0] v;
        ack_hold = 1'b1;
        send_msg(32'h0000_BEEF);
        repeat (5) @(negedge clk);
        chk("R4 req held", mem_req, 1);
        chk("R4 addr held", mem_addr, BASE + 64'h20);
        reg_read(3'h6, v); chk("R4 producer waits", v, 32'h20);
        ack_hold = 1'b0;
        settle();
        reg_read(3'h6, v); chk("R4 producer after ack", v, 32'h30);
        chk("R3 stalled record", words[8], 32'h0000_BEEF);
    endtask

    task automatic t_irq();
        reg_write(3'h0, 32'h1);
        #2 chk("R10 irq masked", irq, 0);
        reg_write(3'h0, 32'h9);
        #2 chk("R10 irq unmasked", irq, 1);
        reg_write(3'h5, 32'h30);
        #2 chk("R10 irq equal offsets", irq, 0);
    endtask

    task automatic t_wrap();
        logic [31:0] v;
        for (int i = 0; i < 2044; i++) send_msg(32'(i));
        settle();
        reg_read(3'h6, v); chk("R5 last slot", v, 32'h7FF0);
        send_msg(32'h1357_2468);
        settle();
        chk("R5 last record", words[13'h1FFC], 32'h1357_2468);
        reg_read(3'h6, v); chk("R5 wrap to zero", v, 0);
        send_msg(32'h0000_CAFE);
        settle();
        chk("R5 record at zero", words[0], 32'h0000_CAFE);
        reg_read(3'h6, v); chk("R5 after wrap", v, 32'h10);
    endtask

    task automatic t_full_stop();
        logic [31:0] v;
        int w0;
        reg_write(3'h5, 32'h30);
        reg_write(3'h0, 32'h1B);
        send_msg(32'h0000_0A0A);
        settle();
        reg_read(3'h6, v); chk("R6 fill to full", v, 32'h20);
        w0 = wcnt;
        @(negedge clk);
        msg_valid = 1'b1; msg_data = 32'h0000_0B0B;
        repeat (6) begin
            @(negedge clk);
            chk("R6 ready low when full", msg_ready, 0);
        end
        chk("R6 no write when full", 64'(wcnt), 64'(w0));
        reg_write(3'h5, 32'h40);
        while (!msg_ready) @(negedge clk);
        @(posedge clk); #1;
        msg_valid = 1'b0;
        settle();
        reg_read(3'h6, v); chk("R6 held message written", v, 32'h30);
        chk("R6 held data", words[12'h8], 32'h0000_0B0B);
    endtask

    task automatic t_drop();
        logic [31:0] v;
        int w0;
        w0 = wcnt;
        reg_write(3'h0, 32'hB);
        send_msg(32'h0000_0D0D);
        settle();
        reg_read(3'h6, v); chk("R7 producer unchanged", v, 32'h30);
        chk("R7 nothing written", 64'(wcnt), 64'(w0));
        reg_read(3'h0, v); chk("R7 overflow set", v, 32'hF);
        reg_write(3'h0, 32'hB);
        reg_read(3'h0, v); chk("R7 overflow sticky", v, 32'hF);
        reg_write(3'h0, 32'hF);
        reg_read(3'h0, v); chk("R7 overflow cleared", v, 32'hB);
    endtask

    task automatic t_no_detect();
        logic [31:0] v;
        int w0;
        w0 = wcnt;
        reg_write(3'h0, 32'h9);
        send_msg(32'h0000_0E0E);
        settle();
        reg_read(3'h6, v); chk("R8 written into full ring", v, 32'h40);
        chk("R8 four writes", 64'(wcnt), 64'(w0 + 4));
        chk("R8 irq with equal offsets", irq, 0);
    endtask

    task automatic t_disable();
        logic [31:0] v;
        int w0;
        w0 = wcnt;
        reg_write(3'h0, 32'h8);
        @(negedge clk);
        msg_valid = 1'b1; msg_data = 32'h0000_0F0F;
        repeat (6) begin
            @(negedge clk);
            chk("R9 ready low disabled", msg_ready, 0);
        end
        chk("R9 no write disabled", 64'(wcnt), 64'(w0));
        reg_read(3'h6, v); chk("R9 producer held", v, 32'h40);
        reg_write(3'h0, 32'h9);
        while (!msg_ready) @(negedge clk);
        @(posedge clk); #1;
        msg_valid = 1'b0;
        settle();
        reg_read(3'h6, v); chk("R9 accepted after enable", v, 32'h50);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8192; i++) words[i] = 32'hDEAD_DEAD;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regmap();
        t_cons_mask();
        t_record();
        t_ack_hold();
        t_irq();
        t_wrap();
        t_full_stop();
        t_drop();
        t_no_detect();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule